// File: doc/BRIEF.md
# Handshake Pipeline FIFO (C-element stage chain)

This block is a self-timed style FIFO modelled in a clocked environment. It is a chain of `STAGES` identical stages. Each stage pairs a two-input Muller C-element with a data register. One C-element input is the request arriving from upstream. The other is the inverted acknowledge coming back from downstream. The C-element output does two jobs: it is the acknowledge returned upstream and the request passed on downstream. Between neighbouring stages the forward request goes through a delay of `DELAY_CYC` clock cycles, with a floor of one. This delay stands in for the delay that would match the logic between latches.

Both channels use four-phase, return-to-zero signalling with bundled data. Each channel carries `DATA_W` data wires and one request wire. The producer raises `in_req` with `in_data` stable and holds both until `in_ack` rises. It then lowers `in_req` and waits for `in_ack` to fall. The consumer reads `out_data` while `out_req` is high and answers with `out_ack` in the same four phases. The environment changes each handshake wire at most once per cycle.

Top module: `mp_fifo_chain`

## Requirements
- R1: While reset is applied and just after it is released, `in_ack`, `out_req` and `out_data` are all 0, and every stage is empty.
- R2: Each stage's C-element output rises on a clock edge when its request input is 1 and its downstream acknowledge is 0. It falls when its request input is 0 and its downstream acknowledge is 1. Otherwise it keeps its value. `in_ack` is the output of stage 0 and `out_req` is the output of the last stage. The downstream acknowledge of the last stage is `out_ack`.
- R3: `in_ack` rises only after an edge on which `in_req` was 1, and falls only after an edge on which `in_req` was 0.
- R4: `out_req` rises only after an edge on which `out_ack` was 0, and falls only after an edge on which `out_ack` was 1.
- R5: The request into stage i (i ≥ 1) is the output of stage i−1 delayed by max(`DELAY_CYC`,1) register stages. For an empty chain, `out_req` rises (STAGES−1)·(D+1) edges after the edge on which stage 0 sampled `in_req` high.
- R6: While `out_req` is high, `out_data` stays constant until `out_ack` is raised.
- R7: Tokens leave in the order they entered, each exactly once, with their data unchanged.
- R8: With `out_ack` held at 0, the chain accepts exactly ceil(STAGES/2) tokens. After that `in_ack` stays at 0 for a request still being held.
- R9: A stage's data register loads its source only on the edge at which its C-element output goes from 0 to 1. Stage 0 loads from `in_data`; stage i loads from stage i−1. The register holds at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Upstream request, four-phase |
| in_ack | output | 1 | Acknowledge to the upstream producer (stage 0 C-element) |
| in_data | input | DATA_W | Bundled input data, valid while `in_req` is high |
| out_req | output | 1 | Request to the downstream consumer (last C-element) |
| out_ack | input | 1 | Downstream acknowledge, four-phase |
| out_data | output | DATA_W | Bundled output data, valid while `out_req` is high |

## Verification
The bench first pushes one token through an empty chain and counts edges until it emerges. Hop delay that is off by one register, or a request that skips a hop, shifts this count. It then stalls the consumer and checks the occupancy at which the producer is refused. A C-element that ignores the downstream acknowledge would overwrite tokens and raise the count. One that waits on the wrong polarity would deadlock below the count. Irregular gaps on both channels then exercise the holding case of every stage. Every cycle, a behavioural history-based model is compared against `in_ack`, `out_req` and `out_data`. A data register that loads while transparent, or on the falling phase, shows up as corrupted or reordered tokens.

// File: rtl/mp_pkg.sv
package mp_pkg;

  // Muller C-element next state: follow when inputs agree, else hold.
  function automatic logic c_next(input logic a, input logic b, input logic q);
    return (a & b) | (q & (a | b));
  endfunction

  // Hop delay in cycles, never below one register.
  function automatic int unsigned hop_delay(input int unsigned d);
    return (d < 1) ? 1 : d;
  endfunction

  // Tokens a stalled chain of n stages can hold.
  function automatic int unsigned stall_capacity(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/mp_req_delay.sv
module mp_req_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned D = mp_pkg::hop_delay(DEPTH);

  logic [D-1:0] sr;

  generate
    if (D == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[D-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[D-1];

endmodule

// File: rtl/mp_c_element.sv
module mp_c_element (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q,
  output logic rise_o
);
  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= mp_pkg::c_next(a, b, q_r);
  end

  assign q      = q_r;
  assign rise_o = a & b & ~q_r;

endmodule

// File: rtl/mp_stage.sv
module mp_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              ack_dn,
  input  logic [DATA_W-1:0] d_src,
  output logic              c_out,
  output logic [DATA_W-1:0] d_out
);
  logic              c_q;
  logic              capture;
  logic [DATA_W-1:0] d_q;

  mp_c_element u_c (
    .clk    (clk),
    .rst_n  (rst_n),
    .a      (req_in),
    .b      (~ack_dn),
    .q      (c_q),
    .rise_o (capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       d_q <= '0;
    else if (capture) d_q <= d_src;
  end

  assign c_out = c_q;
  assign d_out = d_q;

  // R9: a full stage keeps its data
  p_hold_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_q && $past(c_q)) |-> $stable(d_q));

  // R2: a stage empties only once downstream has acknowledged
  p_fall_needs_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(c_q) |-> $past(ack_dn));

endmodule

// File: rtl/mp_fifo_chain.sv
module mp_fifo_chain #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STAGES    = 4,
  parameter int unsigned DELAY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned HOP = mp_pkg::hop_delay(DELAY_CYC);

  logic [STAGES-1:0] c_vec;
  logic [STAGES-1:0] req_at;
  logic [STAGES-1:0] ack_at;
  logic [DATA_W-1:0] d_vec [STAGES];
  logic [DATA_W-1:0] src_at [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign req_at[i] = in_req;
        assign src_at[i] = in_data;
      end else begin : g_body
        mp_req_delay #(.DEPTH(HOP)) u_dly (
          .clk   (clk),
          .rst_n (rst_n),
          .din   (c_vec[i-1]),
          .dout  (req_at[i])
        );
        assign src_at[i] = d_vec[i-1];
      end

      if (i == STAGES - 1) begin : g_tail
        assign ack_at[i] = out_ack;
      end else begin : g_mid
        assign ack_at[i] = c_vec[i+1];
      end

      mp_stage #(.DATA_W(DATA_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (req_at[i]),
        .ack_dn (ack_at[i]),
        .d_src  (src_at[i]),
        .c_out  (c_vec[i]),
        .d_out  (d_vec[i])
      );
    end
  endgenerate

  assign in_ack   = c_vec[0];
  assign out_req  = c_vec[STAGES-1];
  assign out_data = d_vec[STAGES-1];

  // R3: input acknowledge phases follow the request
  p_in_ack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req));
  p_in_ack_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> !$past(in_req));

  // R4: output request phases follow the consumer acknowledge
  p_out_req_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> !$past(out_ack));
  p_out_req_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> $past(out_ack));

  // R6: bundled data steady while offered and not yet acknowledged
  p_out_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_req) && out_req && !$past(out_ack)) |-> $stable(out_data));

endmodule

// File: tb/sim_mp_fifo_chain.sv
module sim_mp_fifo_chain;
  localparam int W   = 8;
  localparam int N   = 4;
  localparam int D   = 2;
  localparam int HL  = 64;
  localparam int CAP = (N + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_req = 1'b0;
  logic out_ack = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ack, out_req;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  int sent = 0;
  int lfsr = 32'h1ace;
  logic [W-1:0] expq[$];

  mp_fifo_chain #(.DATA_W(W), .STAGES(N), .DELAY_CYC(D)) u0 (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .in_data(in_data), .out_req(out_req), .out_ack(out_ack),
    .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural model: stage occupancy by edge history.
  int m_c [N];
  int m_d [N];
  int hist [N][HL];
  int edge_n = 0;

  function automatic int seen(input int j, input int t);
    if (t < 0) return 0;
    return hist[j][t % HL];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_c[i] = 0; m_d[i] = 0;
        for (int k = 0; k < HL; k++) hist[i][k] = 0;
      end
      edge_n = 0;
    end else begin
      int nc [N];
      int nd [N];
      for (int i = 0; i < N; i++) begin
        int rq, ak;
        rq = (i == 0) ? int'(in_req) : seen(i - 1, edge_n - 1 - D);
        ak = (i == N - 1) ? int'(out_ack) : m_c[i + 1];
        if (rq == 1 && ak == 0) nc[i] = 1;
        else if (rq == 0 && ak == 1) nc[i] = 0;
        else nc[i] = m_c[i];
        nd[i] = m_d[i];
        if (nc[i] == 1 && m_c[i] == 0) nd[i] = (i == 0) ? int'(in_data) : m_d[i - 1];
      end
      for (int i = 0; i < N; i++) begin
        m_c[i] = nc[i]; m_d[i] = nd[i];
        hist[i][edge_n % HL] = nc[i];
      end
      edge_n++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 in_ack", int'(in_ack), m_c[0]);
      check("R5 out_req", int'(out_req), m_c[N-1]);
      check("R9 out_data", int'(out_data), m_d[N-1]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic int next_gap();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
    return lfsr % 4;
  endfunction

  task automatic send(input logic [W-1:0] v, input int gap);
    repeat (gap) @(negedge clk);
    expq.push_back(v);
    in_data = v;
    in_req = 1'b1;
    do @(negedge clk); while (!in_ack);
    check("R3 ack-rise-with-req", int'(in_req), 1);
    sent++;
    in_req = 1'b0;
    do @(negedge clk); while (in_ack);
  endtask

  task automatic take(input int gap);
    logic [W-1:0] got;
    logic [W-1:0] want;
    do @(negedge clk); while (!out_req);
    check("R4 req-rise-without-ack", int'(out_ack), 0);
    got = out_data;
    want = (expq.size() > 0) ? expq.pop_front() : '1;
    check("R7 order", int'(got), int'(want));
    repeat (gap) @(negedge clk);
    check("R6 data-steady", int'(out_data), int'(got));
    out_ack = 1'b1;
    do @(negedge clk); while (out_req);
    check("R4 fall-after-ack", int'(out_ack), 1);
    out_ack = 1'b0;
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1 in_ack", int'(in_ack), 0);
    check("R1 out_req", int'(out_req), 0);
    check("R1 out_data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after-release", int'(out_req | in_ack), 0);

    // R5: latency of a lone token through an empty chain
    lat = 0;
    fork
      send(8'h5a, 0);
      begin
        do begin @(negedge clk); lat++; end while (!out_req);
      end
    join
    check("R5 latency", lat, (N - 1) * (D + 1) + 1);
    take(0);

    // streaming, no gaps
    fork
      for (int k = 0; k < 10; k++) send(W'(k * 17 + 3), 0);
      for (int k = 0; k < 10; k++) take(0);
    join

    // R8: stalled consumer
    sent = 0;
    fork
      for (int k = 0; k < CAP + 1; k++) send(W'(8'hc0 + k), 0);
    join_none
    repeat (100) @(negedge clk);
    check("R8 capacity", sent, CAP);
    check("R8 refused ack", int'(in_ack), 0);
    for (int k = 0; k < CAP + 1; k++) take(1);
    wait fork;

    // irregular gaps on both channels
    fork
      for (int k = 0; k < 30; k++) send(W'(k * 29 + 7), next_gap());
      for (int k = 0; k < 30; k++) take(next_gap());
    join
    check("R7 drained", expq.size(), 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule